// File: doc/BRIEF.md
# Linked Descriptor DMA Channel

This block is one DMA channel that takes its work from a chain of descriptors held in memory. Software writes the address of the first descriptor, rings a doorbell and sets the channel enable bit. The channel then reads a descriptor of four 32-bit words: command, source address, target address, and count/link. It moves the described number of transfer units by alternating reads from the source with writes to the target. A unit is 1, 2, 4, 16, 32, 64 or 128 bytes, and each memory access carries at most four bytes.

When a descriptor ends with its link bit set, the channel fetches the next descriptor. That descriptor sits at the chain base plus an 8-bit offset, in 16-byte steps, taken from the top byte of the count/link word. A descriptor that ends unlinked terminates the chain. Termination sets a status flag and can raise an interrupt. A chain whose last link points back into itself therefore runs until software stops it and never interrupts.

The memory side is a request/grant port with read data returned in the granted cycle. The channel always runs in self-triggered mode, with no peripheral handshake.

Top module: `dma_linked_chan`

## Requirements
- R1: After reset the status word, the residue and the interrupt are all zero, and no memory request is made.
- R2: A fetch starts only when the doorbell (write to select 3) and the enable bit (status bit 0) are both set. Starting consumes the doorbell, so re-enabling without a new doorbell write starts nothing.
- R3: The descriptor words are read as 32-bit words at the descriptor address plus 0, 4, 8 and 12, in the order command, source, target, count/link. With status bit 30 set, eight words are read and only the first four are used.
- R4: The size code in command bits 10:8 selects the unit: 0=4, 1=1, 2=2, 3=16, 4=32, 5=64, 6=128 bytes. Each data access is min(unit, 4) bytes, reported on mem_size as log2 of the byte count.
- R5: Command bit 23 makes the source address advance and bit 22 makes the target address advance, each by the access size after every access. A clear bit keeps that address fixed.
- R6: Count/link bits 23:0 are loaded into the residue when a descriptor is accepted, and the residue drops by one after each unit. A write to select 1 while the channel is idle loads the residue directly.
- R7: When a descriptor ends with command bit 0 (link) set, the next descriptor is fetched at the descriptor address register plus (count/link bits 31:24) × 16, and no termination is flagged.
- R8: When a descriptor ends with link clear, status bit 3 (terminated) is set and bit 0 is cleared. irq_o rises only if command bit 1 is set.
- R9: A source or target address not aligned to the unit size, or a descriptor address not aligned to 16 bytes, sets status bit 4 (address error) and clears bit 0, with no data write.
- R10: Size code 7 sets status bit 2 (halt) and clears bit 0, with no data access.
- R11: A write to select 2 loads the enable and bit 30 and clears bits 2, 3, 4 and irq_o. Writing 0 stops a running channel before the next cycle.
- R12: A chain that links back into itself keeps the channel enabled and never raises irq_o or the terminated flag.
- R13: For 1- and 2-byte units, the data moves from the source byte lane to the target byte lane given by the low address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 descriptor address, 1 residue, 2 status, 3 doorbell |
| cfg_wdata | input | 32 | Register write data |
| stat_o | output | 32 | Status: bit0 enable, bit2 halt, bit3 terminated, bit4 address error, bit30 eight-word descriptors |
| residue_o | output | CNT_W | Live unit count |
| irq_o | output | 1 | Termination interrupt, level |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_size | output | 2 | log2 of the access byte count |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 32 | Write data, positioned on its byte lanes |
| mem_gnt | input | 1 | Grant; completes the request this cycle |
| mem_rdata | input | 32 | Read data of the addressed word, valid with the grant |

## Verification
The bench uses the default parameters: 32-bit addresses, 24-bit count and 8-bit link offset, with a 1 KiB memory model behind a randomly withheld grant. The 8-bit offset lets a chain jump forward by several descriptor slots, or back to offset zero for a loop. The grant stalls exercise the hold-until-grant behaviour in the middle of descriptor fetches and data beats. Every unit size, including 128 bytes, can be drawn in the random runs.

// File: rtl/dma_linked_pkg.sv
// Shared encodings of the linked descriptor DMA channel.
// Assumes one channel and 32-bit descriptor words.
package dma_linked_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_CHECK, ST_READ, ST_WRITE, ST_DONE
    } chan_state_e;

    // command word bit positions
    localparam int CMD_LINK   = 0;
    localparam int CMD_TIE    = 1;
    localparam int CMD_TSZ_LO = 8;
    localparam int CMD_DINC   = 22;
    localparam int CMD_SINC   = 23;

    // status word bit positions
    localparam int STS_EN   = 0;
    localparam int STS_HALT = 2;
    localparam int STS_TERM = 3;
    localparam int STS_AERR = 4;
    localparam int STS_D8   = 30;

    // register selects
    localparam logic [1:0] SEL_DADDR = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_STAT  = 2'd2;
    localparam logic [1:0] SEL_BELL  = 2'd3;

    localparam int DESC_SHIFT = 4;
endpackage

// File: rtl/dma_unit_decode.sv
// Turns a 3-bit transfer-size code into unit and access geometry.
// Assumes accesses of at most four bytes; code 7 is reported invalid.
module dma_unit_decode (
    input  logic [2:0] code,
    output logic [2:0] unit_log2,
    output logic [1:0] beat_log2,
    output logic [2:0] beats_log2,
    output logic       valid
);
    // size table and derived access counts
    always_comb begin
        valid = 1'b1;
        case (code)
            3'd0: unit_log2 = 3'd2;
            3'd1: unit_log2 = 3'd0;
            3'd2: unit_log2 = 3'd1;
            3'd3: unit_log2 = 3'd4;
            3'd4: unit_log2 = 3'd5;
            3'd5: unit_log2 = 3'd6;
            3'd6: unit_log2 = 3'd7;
            default: begin
                unit_log2 = 3'd0;
                valid     = 1'b0;
            end
        endcase
        beat_log2  = (unit_log2 >= 3'd2) ? 2'd2 : unit_log2[1:0];
        beats_log2 = (unit_log2 >= 3'd2) ? unit_log2 - 3'd2 : 3'd0;
    end
endmodule

// File: rtl/dma_addr_step.sv
// Address register that loads a start value and optionally advances
// by the access size. Assumes load and step never need to coincide.
module dma_addr_step #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    input  logic              inc_en,
    input  logic [1:0]        step_log2,
    output logic [ADDR_W-1:0] addr
);
    // load has priority over stepping
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= load_val;
        else if (step && inc_en)
            addr <= addr + (ADDR_W'(1) << step_log2);
    end
endmodule

// File: rtl/dma_linked_chan.sv
// One DMA channel driven by linked in-memory descriptors.
// Fetches command/source/target/count-link words, moves units with
// read-then-write beats, follows links relative to the descriptor address
// register. Assumes memory returns read data in the grant cycle and that
// ADDR_W is at most 32.
module dma_linked_chan
    import dma_linked_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24,
    parameter int LINK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       stat_o,
    output logic [CNT_W-1:0]  residue_o,
    output logic              irq_o,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_size,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic [31:0]       mem_rdata
);
    localparam int BEAT_W = 6;

    chan_state_e       state_q;
    logic [ADDR_W-1:0] dar_q, fetch_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [31:0]       cmd_q, srcw_q, dstw_q, cw_q, hold_q;
    logic [2:0]        widx_q;
    logic [BEAT_W-1:0] beat_q, beats_last;
    logic              en_q, halt_q, term_q, aerr_q, d8_q, bell_q, irq_q;

    logic [2:0]        unit_log2, beats_log2;
    logic [1:0]        beat_log2;
    logic              size_ok, misaligned, stat_wr;
    logic [ADDR_W-1:0] unit_mask;
    logic [ADDR_W-1:0] ptr [2];
    logic [ADDR_W-1:0] ptr_init [2];
    logic              ptr_inc [2];
    logic              ptr_load, ptr_step;

    dma_unit_decode u_dec (
        .code      (cmd_q[CMD_TSZ_LO +: 3]),
        .unit_log2 (unit_log2),
        .beat_log2 (beat_log2),
        .beats_log2(beats_log2),
        .valid     (size_ok)
    );

    assign ptr_init[0] = srcw_q[ADDR_W-1:0];
    assign ptr_init[1] = dstw_q[ADDR_W-1:0];
    assign ptr_inc[0]  = cmd_q[CMD_SINC];
    assign ptr_inc[1]  = cmd_q[CMD_DINC];
    assign ptr_load    = (state_q == ST_CHECK);
    assign ptr_step    = (state_q == ST_WRITE) && mem_gnt;

    // source pointer (0) and target pointer (1)
    generate
        for (genvar g = 0; g < 2; g++) begin : g_ptr
            dma_addr_step #(.ADDR_W(ADDR_W)) u_step (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (ptr_load),
                .load_val (ptr_init[g]),
                .step     (ptr_step),
                .inc_en   (ptr_inc[g]),
                .step_log2(beat_log2),
                .addr     (ptr[g])
            );
        end
    endgenerate

    // alignment and beat-count geometry of the current descriptor
    always_comb begin
        unit_mask  = ~({ADDR_W{1'b1}} << unit_log2);
        beats_last = ~({BEAT_W{1'b1}} << beats_log2);
        misaligned = |((srcw_q[ADDR_W-1:0] | dstw_q[ADDR_W-1:0]) & unit_mask);
        stat_wr    = cfg_we && (cfg_sel == SEL_STAT);
    end

    // memory port drive from the current state
    always_comb begin
        mem_req   = (state_q == ST_FETCH) || (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_we    = (state_q == ST_WRITE);
        mem_size  = (state_q == ST_FETCH) ? 2'd2 : beat_log2;
        case (state_q)
            ST_FETCH: mem_addr = fetch_q;
            ST_READ:  mem_addr = ptr[0];
            default:  mem_addr = ptr[1];
        endcase
        mem_wdata = hold_q << {ptr[1][1:0], 3'b000};
    end

    // channel sequencer, register writes and status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dar_q   <= '0;
            fetch_q <= '0;
            cnt_q   <= '0;
            cmd_q   <= '0;
            srcw_q  <= '0;
            dstw_q  <= '0;
            cw_q    <= '0;
            hold_q  <= '0;
            widx_q  <= '0;
            beat_q  <= '0;
            en_q    <= 1'b0;
            halt_q  <= 1'b0;
            term_q  <= 1'b0;
            aerr_q  <= 1'b0;
            d8_q    <= 1'b0;
            bell_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cfg_we && cfg_sel == SEL_DADDR)
                        dar_q <= cfg_wdata[ADDR_W-1:0];
                    if (cfg_we && cfg_sel == SEL_COUNT)
                        cnt_q <= cfg_wdata[CNT_W-1:0];
                    if (en_q && bell_q) begin
                        bell_q <= 1'b0;
                        if (|dar_q[DESC_SHIFT-1:0]) begin
                            aerr_q <= 1'b1;
                            en_q   <= 1'b0;
                        end else begin
                            fetch_q <= dar_q;
                            widx_q  <= '0;
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_gnt) begin
                        case (widx_q)
                            3'd0:    cmd_q  <= mem_rdata;
                            3'd1:    srcw_q <= mem_rdata;
                            3'd2:    dstw_q <= mem_rdata;
                            3'd3:    cw_q   <= mem_rdata;
                            default: ;
                        endcase
                        widx_q  <= widx_q + 3'd1;
                        fetch_q <= fetch_q + ADDR_W'(4);
                        if (widx_q == (d8_q ? 3'd7 : 3'd3))
                            state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    beat_q <= '0;
                    if (!size_ok) begin
                        halt_q  <= 1'b1;
                        en_q    <= 1'b0;
                        state_q <= ST_IDLE;
                    end else if (misaligned) begin
                        aerr_q  <= 1'b1;
                        en_q    <= 1'b0;
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q   <= cw_q[CNT_W-1:0];
                        state_q <= (cw_q[CNT_W-1:0] == '0) ? ST_DONE : ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_gnt) begin
                        hold_q  <= mem_rdata >> {ptr[0][1:0], 3'b000};
                        state_q <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_gnt) begin
                        if (beat_q == beats_last) begin
                            beat_q  <= '0;
                            cnt_q   <= cnt_q - CNT_W'(1);
                            state_q <= (cnt_q == CNT_W'(1)) ? ST_DONE : ST_READ;
                        end else begin
                            beat_q  <= beat_q + BEAT_W'(1);
                            state_q <= ST_READ;
                        end
                    end
                end
                ST_DONE: begin
                    if (cmd_q[CMD_LINK]) begin
                        fetch_q <= dar_q + (ADDR_W'(cw_q[CNT_W +: LINK_W]) << DESC_SHIFT);
                        widx_q  <= '0;
                        state_q <= ST_FETCH;
                    end else begin
                        term_q  <= 1'b1;
                        en_q    <= 1'b0;
                        irq_q   <= cmd_q[CMD_TIE];
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase

            if (cfg_we && cfg_sel == SEL_BELL)
                bell_q <= 1'b1;

            if (stat_wr) begin
                en_q   <= cfg_wdata[STS_EN];
                d8_q   <= cfg_wdata[STS_D8];
                halt_q <= 1'b0;
                term_q <= 1'b0;
                aerr_q <= 1'b0;
                irq_q  <= 1'b0;
                if (!cfg_wdata[STS_EN])
                    state_q <= ST_IDLE;
            end
        end
    end

    // status word assembly
    always_comb begin
        stat_o           = '0;
        stat_o[STS_EN]   = en_q;
        stat_o[STS_HALT] = halt_q;
        stat_o[STS_TERM] = term_q;
        stat_o[STS_AERR] = aerr_q;
        stat_o[STS_D8]   = d8_q;
    end

    assign residue_o = cnt_q;
    assign irq_o     = irq_q;
endmodule

// File: rtl/dma_linked_chan_chk.sv
// Port-level properties of the linked descriptor DMA channel.
// Assumes the status bit positions of dma_linked_pkg.
module dma_linked_chan_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [1:0]        cfg_sel,
    input logic [31:0]       cfg_wdata,
    input logic [31:0]       stat_o,
    input logic [CNT_W-1:0]  residue_o,
    input logic              irq_o,
    input logic              mem_req,
    input logic              mem_we,
    input logic [1:0]        mem_size,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_gnt,
    input logic [31:0]       mem_rdata
);
    logic stat_wr;
    assign stat_wr = cfg_we && (cfg_sel == 2'd2);

    // R8
    irq_implies_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (stat_o[3] && !stat_o[0]));

    // R9
    aerr_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[4] |-> !stat_o[0]);

    // R10
    halt_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[2] |-> !stat_o[0]);

    // R12
    irq_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $fell(stat_o[0]));

    // R11
    stop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !cfg_wdata[0]) |=> (!mem_req && !irq_o && stat_o[4:2] == 3'b000));

    // R4
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !stat_wr) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind dma_linked_chan dma_linked_chan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_dma_linked_chan.sv
module test_dma_linked_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] stat_o;
    logic [23:0] residue_o;
    logic        irq_o;
    logic        mem_req, mem_we, mem_gnt;
    logic [1:0]  mem_size;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    int total = 0;
    int bad = 0;

    logic [31:0] mem [256];
    logic [31:0] ref_mem [256];
    logic        gnt_en = 1'b0;
    logic        pre_we = 1'b0;
    logic [7:0]  pre_idx = '0;
    logic [31:0] pre_data = '0;
    logic        mon_clr = 1'b0;
    int          rd_cnt, wr_cnt, irq_rises, term_rises;
    logic [2:0]  size_mask;
    logic [31:0] rd_log [16];
    logic        irq_prev, term_prev;

    always #5 clk = ~clk;

    dma_linked_chan i_dma_linked_chan (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .stat_o(stat_o), .residue_o(residue_o),
        .irq_o(irq_o), .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata)
    );

    assign mem_gnt   = mem_req && gnt_en;
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(negedge clk) gnt_en <= ($urandom % 4) != 0;

    // memory model, preload port and access monitor
    always @(posedge clk) begin
        if (pre_we) mem[pre_idx] <= pre_data;
        if (mon_clr) begin
            rd_cnt <= 0; wr_cnt <= 0; irq_rises <= 0; term_rises <= 0; size_mask <= '0;
        end else if (rst_n) begin
            if (mem_req && mem_gnt && mem_we) begin
                for (int k = 0; k < (1 << mem_size); k++)
                    mem[mem_addr[9:2]][(int'(mem_addr[1:0]) + k) * 8 +: 8]
                        <= mem_wdata[(int'(mem_addr[1:0]) + k) * 8 +: 8];
                wr_cnt <= wr_cnt + 1;
                size_mask[mem_size] <= 1'b1;
            end
            if (mem_req && mem_gnt && !mem_we) begin
                if (rd_cnt < 16) rd_log[rd_cnt] <= mem_addr;
                rd_cnt <= rd_cnt + 1;
            end
            if (irq_o && !irq_prev) irq_rises <= irq_rises + 1;
            if (stat_o[3] && !term_prev) term_rises <= term_rises + 1;
        end
        irq_prev  <= irq_o;
        term_prev <= stat_o[3];
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic put_word(input int addr, input logic [31:0] val);
        @(negedge clk);
        pre_we = 1'b1; pre_idx = 8'(addr >> 2); pre_data = val;
        ref_mem[addr >> 2] = val;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic clear_mon();
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
    endtask

    function automatic int unit_bytes(input logic [2:0] code);
        case (code)
            3'd0: return 4;   3'd1: return 1;  3'd2: return 2;  3'd3: return 16;
            3'd4: return 32;  3'd5: return 64; 3'd6: return 128;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] mk_cmd(input int tsz, input bit sinc, input bit dinc,
                                           input bit link, input bit tie);
        return (32'(sinc) << 23) | (32'(dinc) << 22) | (32'(tsz) << 8) |
               (32'(tie) << 1) | 32'(link);
    endfunction

    function automatic logic [31:0] mk_cw(input int cnt, input int off);
        return {8'(off), 24'(cnt)};
    endfunction

    // reference data movement, byte by byte
    task automatic ref_copy(input logic [31:0] cmd, input int src, input int dst, input int cnt);
        int u = unit_bytes(cmd[10:8]);
        int bb = (u < 4) ? u : 4;
        int s = src;
        int d = dst;
        for (int n = 0; n < cnt; n++)
            for (int b = 0; b < u / bb; b++) begin
                for (int k = 0; k < bb; k++)
                    ref_mem[(d + k) >> 2][((d + k) % 4) * 8 +: 8] = ref_mem[(s + k) >> 2][((s + k) % 4) * 8 +: 8];
                if (cmd[23]) s += bb;
                if (cmd[22]) d += bb;
            end
    endtask

    task automatic put_desc(input int at, input logic [31:0] cmd, input int src,
                            input int dst, input logic [31:0] cw);
        put_word(at, cmd); put_word(at + 4, 32'(src));
        put_word(at + 8, 32'(dst)); put_word(at + 12, cw);
    endtask

    task automatic start(input int dar, input bit d8);
        clear_mon();
        cfg_write(2'd0, 32'(dar));
        cfg_write(2'd3, 32'd0);
        cfg_write(2'd2, d8 ? 32'h4000_0001 : 32'h1);
    endtask

    task automatic wait_idle(input string rq);
        int n = 0;
        while (stat_o[0] && n < 5000) begin @(negedge clk); n++; end
        if (n >= 5000) chk({rq, " channel stuck"}, 32'd1, 32'd0);
        repeat (2) @(negedge clk);
    endtask

    task automatic cmp_mem(input string rq);
        int mism = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) mism++;
        chk({rq, " memory image mismatches"}, 32'(mism), 32'd0);
    endtask

    initial begin
        #(10 * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) begin mem[i] = '0; ref_mem[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", stat_o, 32'h0);
        chk("R1 residue", 32'(residue_o), 32'h0);
        chk("R1 irq", 32'(irq_o), 32'h0);
        chk("R1 req", 32'(mem_req), 32'h0);
        for (int a = 32'h200; a < 32'h400; a += 4) put_word(a, $urandom);

        // R6 residue preload while idle
        cfg_write(2'd1, 32'd5);
        chk("R6 residue preload", 32'(residue_o), 32'd5);

        // R2 start conditions
        put_desc(32'h000, mk_cmd(0, 1, 1, 0, 1), 32'h200, 32'h300, mk_cw(4, 0));
        cfg_write(2'd0, 32'h000);
        clear_mon();
        cfg_write(2'd2, 32'h1);
        repeat (8) @(negedge clk);
        chk("R2 enable without doorbell", 32'(rd_cnt), 32'd0);
        cfg_write(2'd2, 32'h0);
        cfg_write(2'd3, 32'h0);
        repeat (8) @(negedge clk);
        chk("R2 doorbell without enable", 32'(rd_cnt), 32'd0);
        cfg_write(2'd2, 32'h1);
        ref_copy(mk_cmd(0, 1, 1, 0, 1), 32'h200, 32'h300, 4);
        wait_idle("R2");
        chk("R3 fetch word 0", rd_log[0], 32'h000);
        chk("R3 fetch word 1", rd_log[1], 32'h004);
        chk("R3 fetch word 2", rd_log[2], 32'h008);
        chk("R3 fetch word 3", rd_log[3], 32'h00C);
        chk("R3 read count", 32'(rd_cnt), 32'd8);
        chk("R4 4-byte access size", 32'(size_mask), 32'b100);
        chk("R8 status after end", stat_o, 32'h8);
        chk("R8 irq with TIE", 32'(irq_o), 32'd1);
        chk("R6 residue at end", 32'(residue_o), 32'd0);
        cmp_mem("R5 word copy");
        clear_mon();
        cfg_write(2'd2, 32'h1);
        repeat (8) @(negedge clk);
        chk("R2 doorbell consumed", 32'(rd_cnt), 32'd0);
        chk("R11 write clears terminated and irq", {stat_o[31:1], irq_o}, 32'h0);
        cfg_write(2'd2, 32'h0);

        // R8 end without TIE
        put_desc(32'h000, mk_cmd(0, 1, 1, 0, 0), 32'h204, 32'h310, mk_cw(1, 0));
        ref_copy(mk_cmd(0, 1, 1, 0, 0), 32'h204, 32'h310, 1);
        start(32'h000, 0); wait_idle("R8");
        chk("R8 no irq without TIE", 32'(irq_o), 32'd0);
        chk("R8 terminated flag", stat_o, 32'h8);

        // R13 byte lanes
        put_desc(32'h000, mk_cmd(1, 1, 1, 0, 0), 32'h201, 32'h302, mk_cw(5, 0));
        ref_copy(mk_cmd(1, 1, 1, 0, 0), 32'h201, 32'h302, 5);
        start(32'h000, 0); wait_idle("R13");
        cmp_mem("R13 byte lane copy");
        chk("R4 byte access size", 32'(size_mask), 32'b001);

        // R5 fixed source, 16-byte units
        put_desc(32'h000, mk_cmd(3, 0, 1, 0, 0), 32'h210, 32'h320, mk_cw(2, 0));
        ref_copy(mk_cmd(3, 0, 1, 0, 0), 32'h210, 32'h320, 2);
        start(32'h000, 0); wait_idle("R5");
        cmp_mem("R5 fixed source");
        chk("R4 beats per 16-byte unit", 32'(wr_cnt), 32'd8);

        // R7 linked chain of three
        put_desc(32'h040, mk_cmd(0, 1, 1, 1, 1), 32'h200, 32'h300, mk_cw(2, 2));
        put_desc(32'h060, mk_cmd(2, 1, 1, 1, 1), 32'h212, 32'h31A, mk_cw(3, 5));
        put_desc(32'h090, mk_cmd(3, 1, 1, 0, 1), 32'h220, 32'h340, mk_cw(2, 0));
        ref_copy(mk_cmd(0, 1, 1, 1, 1), 32'h200, 32'h300, 2);
        ref_copy(mk_cmd(2, 1, 1, 1, 1), 32'h212, 32'h31A, 3);
        ref_copy(mk_cmd(3, 1, 1, 0, 1), 32'h220, 32'h340, 2);
        start(32'h040, 0); wait_idle("R7");
        cmp_mem("R7 chain copy");
        chk("R7 single interrupt", 32'(irq_rises), 32'd1);
        chk("R7 single termination", 32'(term_rises), 32'd1);
        chk("R7 second fetch address", rd_log[6], 32'h060);

        // R3 eight-word descriptors
        put_desc(32'h0C0, mk_cmd(0, 1, 1, 0, 0), 32'h230, 32'h360, mk_cw(2, 0));
        for (int a = 32'h0D0; a < 32'h0E0; a += 4) put_word(a, 32'hFFFF_FFFF);
        ref_copy(mk_cmd(0, 1, 1, 0, 0), 32'h230, 32'h360, 2);
        start(32'h0C0, 1); wait_idle("R3");
        chk("R3 eight-word read count", 32'(rd_cnt), 32'd10);
        chk("R3 eight-word status", stat_o, 32'h4000_0008);
        cmp_mem("R3 eight-word copy");

        // R9 misaligned data address, then misaligned descriptor
        put_desc(32'h000, mk_cmd(0, 1, 1, 0, 1), 32'h202, 32'h300, mk_cw(1, 0));
        start(32'h000, 0); wait_idle("R9");
        chk("R9 address error status", stat_o, 32'h10);
        chk("R9 no write", 32'(wr_cnt), 32'd0);
        cfg_write(2'd2, 32'h0);
        chk("R11 stop write clears error", stat_o, 32'h0);
        start(32'h004, 0); wait_idle("R9b");
        chk("R9 descriptor misaligned", stat_o, 32'h10);
        chk("R9 no fetch", 32'(rd_cnt), 32'd0);

        // R10 reserved size code
        put_desc(32'h000, mk_cmd(7, 1, 1, 0, 1), 32'h200, 32'h300, mk_cw(1, 0));
        start(32'h000, 0); wait_idle("R10");
        chk("R10 halt status", stat_o, 32'h4);
        chk("R10 no data access", 32'(rd_cnt + wr_cnt), 32'd4);

        // R12 circular chain, then R11 stop
        put_desc(32'h0E0, mk_cmd(0, 1, 1, 1, 1), 32'h200, 32'h380, mk_cw(2, 0));
        ref_copy(mk_cmd(0, 1, 1, 1, 1), 32'h200, 32'h380, 2);
        start(32'h0E0, 0);
        repeat (300) @(negedge clk);
        chk("R12 still enabled no flags", stat_o, 32'h1);
        chk("R12 no interrupt", 32'(irq_rises), 32'd0);
        chk("R12 keeps moving data", 32'(wr_cnt > 4), 32'd1);
        cfg_write(2'd2, 32'h0);
        chk("R11 stop running channel", {stat_o[31:1], mem_req}, 32'h0);
        repeat (2) @(negedge clk);
        cmp_mem("R12 circular copy");

        // random descriptors: R4 R5 R6
        for (int it = 0; it < 6; it++) begin
            int tsz = $urandom_range(0, 6);
            int u = unit_bytes(3'(tsz));
            int lim = (128 / u < 8) ? 128 / u : 8;
            int cnt = 1 + int'($urandom % lim);
            int span = u * cnt;
            int src = 32'h200 + int'($urandom % ((256 - span) / u + 1)) * u;
            int dst = 32'h300 + int'($urandom % ((256 - span) / u + 1)) * u;
            logic [31:0] cmd = mk_cmd(tsz, 1'($urandom), 1'($urandom), 0, 1);
            put_desc(32'h000, cmd, src, dst, mk_cw(cnt, 0));
            ref_copy(cmd, src, dst, cnt);
            start(32'h000, 0); wait_idle("R4 random");
            cmp_mem("R5 random copy");
            chk("R4 random status", stat_o, 32'h8);
            chk("R6 random residue", 32'(residue_o), 32'd0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule